// File: doc/BRIEF.md
# Cache Tag Maintenance Sequencer

This block holds the tag array of a four-way set-associative cache as internal registers and carries out maintenance on it. A requester issues one command at a time: a range operation (invalidate, clean, write back, lock, unlock) over a start address plus a length, a sweep over every entry (invalidate, clean, write back), or a global control command (disable, suspend, resume). The block walks the affected lines one per cycle, edits the matching tag entries in place and pulses an acknowledge with an error flag when it has finished.

For write back, every dirty line it meets is offered on a write-back port together with its line address. The block holds that request until the port acknowledges it, and only then clears the dirty bit. Lines whose address falls outside the cacheable window are skipped without any effect. A refill port installs whole entries, and a probe port reads any entry back, which stands in for the lookup path. A hold output tells the CPU side that cache access is blocked.

Top module: `cache_tag_sweeper`

## Requirements
- R1: After reset every tag entry reads as zero, and `ack`, `busy`, `wb_valid` and `cpu_hold` are low.
- R2: An entry is 32 bits. Bit 0 is dirty, bits 14:1 are the tag, bit 15 is valid, bits 18:16 are the FIFO age, bit 19 is lock, bits 22:20 are the attribute, bit 23 is access and bits 31:24 are reserved. Entry (set s, way w) sits at index s*4+w on the install and probe ports. A line address a maps to set `(a-WIN_BASE)[OFF+:IDX]` and to tag `(a-WIN_BASE)[OFF+IDX+:14]`. A line hits when an entry in that set is valid and its tag matches.
- R3: The start address is rounded down to a line boundary. With `len_in_bytes`=0, `req_len` counts lines. With `len_in_bytes`=1, the block covers every line touched by bytes addr..addr+len-1.
- R4: Invalidate (cmd 0) clears only the valid bit of each hit line. FIFO age, attribute, tag and dirty stay as they were, and lines not covered are untouched.
- R5: Lock (cmd 3) sets the lock bit of each hit line and unlock (cmd 4) clears it. Range invalidate and invalidate-all both leave a locked line valid.
- R6: Clean (cmd 1) clears the dirty bit of each hit line and issues no write-back request.
- R7: Write back (cmd 2) presents each dirty hit line on `wb_valid`/`wb_addr`, in ascending address order. The request stays stable until `wb_ack`, and the dirty bit is cleared after the acknowledge.
- R8: Lines outside [WIN_BASE, WIN_BASE+WIN_SIZE) are skipped. The operation still acknowledges with `err`=0 and changes nothing.
- R9: A length of zero, more than 4 MB worth of lines, more than 4 MB of bytes, or a command code of 11 to 15 acknowledges with `err`=1 without touching the array.
- R10: Sweeps visit set 0 to the last set and, within each set, way 0 to way 3, acting on valid entries only. Cmd 5 invalidates unlocked entries, cmd 6 cleans them and cmd 7 writes back the dirty ones.
- R11: Disable (cmd 8) clears the valid bit of every entry, locked ones included, and raises `cpu_hold`. Suspend (cmd 9) raises `cpu_hold` and leaves the tags intact. Resume (cmd 10) lowers `cpu_hold`.
- R12: `ack` is a one-cycle pulse that occurs only while idle. Requests and installs made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | One-cycle command strobe, accepted when idle |
| cmd | input | 4 | Command code |
| req_addr | input | 32 | Start address of a range command |
| req_len | input | 32 | Line count or byte size |
| len_in_bytes | input | 1 | 1: `req_len` is a byte size |
| ack | output | 1 | Completion pulse |
| err | output | 1 | Invalid-argument flag, valid with `ack` |
| busy | output | 1 | A command is in progress |
| wb_valid | output | 1 | Write-back request pending |
| wb_addr | output | 32 | Line address to write back |
| wb_ack | input | 1 | Write-back accepted |
| ins_en | input | 1 | Install an entry (idle only) |
| ins_set | input | IDX | Set of the installed entry |
| ins_way | input | 2 | Way of the installed entry |
| ins_data | input | 32 | Entry value to install |
| prb_set | input | IDX | Set to probe |
| prb_way | input | 2 | Way to probe |
| prb_data | output | 32 | Probed entry |
| cpu_hold | output | 1 | CPU access to the cache blocked |

## Verification
The bench builds the block with a 512-byte cache and 16-byte lines, which gives eight sets and 32 entries, and keeps the default 16 MB window. With so few sets, a range of two or three lines can wrap into neighbouring sets, and tags sharing a set can be laid out by hand. A sweep over the whole array finishes in a few dozen cycles, so write-back ordering and locked-line survival are checked over the complete array. The 4 MB limits stay at full size and are probed only through the rejection path.

// File: rtl/cache_tag_sweeper.sv
module cache_tag_sweeper #(
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 4,
  parameter int MAX_SPAN    = 4194304,
  parameter logic [31:0] WIN_BASE = 32'h4000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0100_0000,
  localparam int OFF  = $clog2(LINE_BYTES),
  localparam int SETS = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int IDX  = $clog2(SETS),
  localparam int WW   = $clog2(WAYS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [3:0]     cmd,
  input  logic [31:0]    req_addr,
  input  logic [31:0]    req_len,
  input  logic           len_in_bytes,
  output logic           ack,
  output logic           err,
  output logic           busy,
  output logic           wb_valid,
  output logic [31:0]    wb_addr,
  input  logic           wb_ack,
  input  logic           ins_en,
  input  logic [IDX-1:0] ins_set,
  input  logic [WW-1:0]  ins_way,
  input  logic [31:0]    ins_data,
  input  logic [IDX-1:0] prb_set,
  input  logic [WW-1:0]  prb_way,
  output logic [31:0]    prb_data,
  output logic           cpu_hold
);
  localparam int N        = SETS * WAYS;
  localparam int PW       = IDX + WW;
  localparam int TAGW     = 14;
  localparam int MAXLINES = MAX_SPAN / LINE_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_SWEEP, S_WB} st_t;

  logic [31:0]   tags [N];
  st_t           st;
  logic [3:0]    op;
  logic [31:0]   cur, rem, wba;
  logic [PW-1:0] ptr, wbi;
  logic          sweep, hold;

  logic [31:0]   off, aligned, nsel, line_addr, sw_addr, e;
  logic [32:0]   span;
  logic          in_win, hit, act_ok, is_wb, go_wb, step, last, range_bad;
  logic [IDX-1:0] wset;
  logic [TAGW-1:0] wtag;
  logic [WW-1:0] hway;
  logic [PW-1:0] act_idx;

  assign off    = cur - WIN_BASE;
  assign in_win = (cur >= WIN_BASE) && (off < WIN_SIZE);
  assign wset   = off[OFF +: IDX];
  assign wtag   = off[OFF+IDX +: TAGW];

  always_comb begin
    hit  = 1'b0;
    hway = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && tags[{wset, WW'(w)}][15] && tags[{wset, WW'(w)}][14:1] == wtag) begin
        hit  = 1'b1;
        hway = WW'(w);
      end
    end
  end

  assign act_idx  = (st == S_SWEEP) ? ptr : {wset, hway};
  assign e        = tags[act_idx];
  assign act_ok   = (st == S_SWEEP) ? e[15] : (in_win && hit);
  assign is_wb    = (op == 4'd2) || (op == 4'd7);
  assign go_wb    = (st == S_WALK || st == S_SWEEP) && act_ok && is_wb && e[0];
  assign step     = ((st == S_WALK || st == S_SWEEP) && !go_wb) || (st == S_WB && wb_ack);
  assign last     = sweep ? (ptr == PW'(N - 1)) : (rem == 32'd1);
  assign sw_addr  = WIN_BASE + (32'(e[14:1]) << (OFF + IDX)) + (32'(ptr[PW-1:WW]) << OFF);
  assign line_addr = sweep ? sw_addr : cur;

  assign aligned  = req_addr & ~32'(LINE_BYTES - 1);
  assign span     = {1'b0, req_addr & 32'(LINE_BYTES - 1)} + {1'b0, req_len} + 33'(LINE_BYTES - 1);
  assign nsel     = len_in_bytes ? 32'(span >> OFF) : req_len;
  assign range_bad = (req_len == 32'd0) ||
                     (len_in_bytes ? (req_len > 32'(MAX_SPAN)) : (req_len > 32'(MAXLINES)));

  assign busy     = (st != S_IDLE);
  assign wb_valid = (st == S_WB);
  assign wb_addr  = wba;
  assign cpu_hold = hold;
  assign prb_data = tags[{prb_set, prb_way}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; cur <= '0; rem <= '0; ptr <= '0; sweep <= 1'b0;
      wbi <= '0; wba <= '0; ack <= 1'b0; err <= 1'b0; hold <= 1'b0;
      for (int i = 0; i < N; i++) tags[i] <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            op  <= cmd;
            err <= 1'b0;
            if (cmd <= 4'd4) begin
              if (range_bad) begin
                ack <= 1'b1;
                err <= 1'b1;
              end else begin
                cur   <= aligned;
                rem   <= nsel;
                sweep <= 1'b0;
                st    <= S_WALK;
              end
            end else if (cmd <= 4'd7) begin
              ptr   <= '0;
              sweep <= 1'b1;
              st    <= S_SWEEP;
            end else begin
              ack <= 1'b1;
              case (cmd)
                4'd8: begin
                  for (int i = 0; i < N; i++) tags[i][15] <= 1'b0;
                  hold <= 1'b1;
                end
                4'd9:  hold <= 1'b1;
                4'd10: hold <= 1'b0;
                default: err <= 1'b1;
              endcase
            end
          end else if (ins_en) begin
            tags[{ins_set, ins_way}] <= ins_data;
          end
        end
        S_WALK, S_SWEEP: begin
          if (go_wb) begin
            st  <= S_WB;
            wbi <= act_idx;
            wba <= line_addr;
          end else if (act_ok) begin
            case (op)
              4'd0, 4'd5: if (!e[19]) tags[act_idx][15] <= 1'b0;
              4'd1, 4'd6: tags[act_idx][0] <= 1'b0;
              4'd3:       tags[act_idx][19] <= 1'b1;
              4'd4:       tags[act_idx][19] <= 1'b0;
              default: ;
            endcase
          end
        end
        S_WB: if (wb_ack) tags[wbi][0] <= 1'b0;
        default: st <= S_IDLE;
      endcase
      if (step) begin
        if (last) begin
          st  <= S_IDLE;
          ack <= 1'b1;
        end else begin
          cur <= cur + 32'(LINE_BYTES);
          rem <= rem - 32'd1;
          ptr <= ptr + 1'b1;
          st  <= sweep ? S_SWEEP : S_WALK;
        end
      end
    end
  end

  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ack |=> wb_valid && $stable(wb_addr));

  a_r8_wb_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_addr[OFF-1:0] == '0) && (wb_addr >= WIN_BASE) && (wb_addr - WIN_BASE < WIN_SIZE));

  a_r12_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy);

  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !req |=> !ack);

  a_r11_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_hold) |-> ack && !err);

  a_r9_err_direct: assert property (@(posedge clk) disable iff (!rst_n)
    ack && err |-> !$past(busy));
endmodule

// File: tb/tb_cache_tag_sweeper.sv
module tb_cache_tag_sweeper;
  localparam logic [31:0] B = 32'h4000_0000;
  localparam logic [31:0] WSZ = 32'h0100_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, len_in_bytes = 1'b0, wb_ack = 1'b0, ins_en = 1'b0;
  logic [3:0]  cmd = '0;
  logic [31:0] req_addr = '0, req_len = '0, ins_data = '0;
  logic [2:0]  ins_set = '0, prb_set = '0;
  logic [1:0]  ins_way = '0, prb_way = '0;
  logic        ack, err, busy, wb_valid, cpu_hold;
  logic [31:0] wb_addr, prb_data;

  int checks = 0, errors = 0, wb_n = 0, wcnt = 0;
  logic [31:0] wb_log [16];
  logic        last_err;

  always #10 clk = ~clk;

  cache_tag_sweeper #(.CACHE_BYTES(512), .LINE_BYTES(16)) dut (
    .clk, .rst_n, .req, .cmd, .req_addr, .req_len, .len_in_bytes,
    .ack, .err, .busy, .wb_valid, .wb_addr, .wb_ack,
    .ins_en, .ins_set, .ins_way, .ins_data,
    .prb_set, .prb_way, .prb_data, .cpu_hold);

  function automatic logic [31:0] mk(int t, bit v, bit d, bit l, int f);
    return {8'h00, 1'b0, 3'b010, l, 3'(f), v, 14'(t), d};
  endfunction

  function automatic logic [31:0] la(int t, int s);
    return B + (32'(t) << 7) + (32'(s) << 4);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic install(input int s, input int w, input logic [31:0] d);
    @(negedge clk);
    ins_en = 1'b1; ins_set = 3'(s); ins_way = 2'(w); ins_data = d;
    @(negedge clk);
    ins_en = 1'b0;
  endtask

  task automatic probe(input int s, input int w, output logic [31:0] d);
    @(negedge clk);
    prb_set = 3'(s); prb_way = 2'(w);
    #1 d = prb_data;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 32; i++) install(i / 4, i % 4, 32'h0);
  endtask

  task automatic run(input logic [3:0] c, input logic [31:0] a, input logic [31:0] n, input bit byt);
    @(negedge clk);
    req = 1'b1; cmd = c; req_addr = a; req_len = n; len_in_bytes = byt;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (ack) begin
        last_err = err;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pchk(input string r, input int s, input int w, input logic [31:0] exp);
    logic [31:0] d;
    probe(s, w, d);
    chk(r, d, exp);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (wb_ack) begin
        wb_ack = 1'b0;
        wcnt = 0;
      end else if (wb_valid) begin
        wcnt++;
        if (wcnt == 3) begin
          wb_ack = 1'b1;
          if (wb_n < 16) wb_log[wb_n] = wb_addr;
          wb_n++;
        end
      end
    end
  end

  task automatic t_reset();
    logic [31:0] acc = '0, d;
    for (int i = 0; i < 32; i++) begin
      probe(i / 4, i % 4, d);
      acc = acc | d;
    end
    chk("R1 entries zero", acc, 32'h0);
    chk("R1 outputs low", {28'h0, ack, busy, wb_valid, cpu_hold}, 32'h0);
  endtask

  task automatic t_inv();
    clear_all();
    install(1, 0, mk(5, 1, 1, 0, 3));
    install(2, 1, mk(5, 1, 0, 0, 6));
    install(1, 2, mk(6, 1, 0, 0, 1));
    install(3, 3, mk(5, 1, 0, 0, 0));
    run(4'd0, la(5, 1) + 7, 2, 1'b0);
    chk("R9 good range err", {31'h0, last_err}, 32'h0);
    pchk("R4 R2 hit line invalid, fifo kept", 1, 0, mk(5, 0, 1, 0, 3));
    pchk("R3 second line covered", 2, 1, mk(5, 0, 0, 0, 6));
    pchk("R4 other tag untouched", 1, 2, mk(6, 1, 0, 0, 1));
    pchk("R3 line past range untouched", 3, 3, mk(5, 1, 0, 0, 0));
  endtask

  task automatic t_bytes();
    clear_all();
    install(4, 1, mk(7, 1, 0, 0, 2));
    install(5, 0, mk(7, 1, 0, 0, 2));
    install(6, 0, mk(7, 1, 0, 0, 2));
    run(4'd0, la(7, 4) + 12, 8, 1'b1);
    pchk("R3 byte span first line", 4, 1, mk(7, 0, 0, 0, 2));
    pchk("R3 byte span second line", 5, 0, mk(7, 0, 0, 0, 2));
    pchk("R3 byte span stops", 6, 0, mk(7, 1, 0, 0, 2));
  endtask

  task automatic t_lock();
    clear_all();
    install(0, 3, mk(2, 1, 0, 0, 4));
    run(4'd3, la(2, 0), 1, 1'b0);
    pchk("R5 lock sets bit", 0, 3, mk(2, 1, 0, 1, 4));
    run(4'd0, la(2, 0), 1, 1'b0);
    pchk("R5 locked survives invalidate", 0, 3, mk(2, 1, 0, 1, 4));
    run(4'd4, la(2, 0), 1, 1'b0);
    pchk("R5 unlock clears bit", 0, 3, mk(2, 1, 0, 0, 4));
    run(4'd0, la(2, 0), 1, 1'b0);
    pchk("R5 unlocked invalidated", 0, 3, mk(2, 0, 0, 0, 4));
  endtask

  task automatic t_clean();
    int n0;
    clear_all();
    install(6, 2, mk(9, 1, 1, 0, 5));
    n0 = wb_n;
    run(4'd1, la(9, 6), 1, 1'b0);
    pchk("R6 clean clears dirty", 6, 2, mk(9, 1, 0, 0, 5));
    chk("R6 no write-back", 32'(wb_n), 32'(n0));
  endtask

  task automatic t_wb();
    clear_all();
    wb_n = 0;
    install(0, 1, mk(3, 1, 1, 0, 0));
    install(1, 0, mk(3, 1, 0, 0, 0));
    install(2, 3, mk(3, 1, 1, 0, 2));
    run(4'd2, la(3, 0), 3, 1'b0);
    chk("R7 two write-backs", 32'(wb_n), 32'd2);
    chk("R7 first address", wb_log[0], la(3, 0));
    chk("R7 second address", wb_log[1], la(3, 2));
    pchk("R7 dirty cleared", 0, 1, mk(3, 1, 0, 0, 0));
    pchk("R7 dirty cleared 2", 2, 3, mk(3, 1, 0, 0, 2));
  endtask

  task automatic t_window();
    int n0;
    clear_all();
    install(3, 0, mk(0, 1, 1, 0, 1));
    run(4'd0, B - 32'h100 + 32'h30, 1, 1'b0);
    chk("R8 below window err", {31'h0, last_err}, 32'h0);
    pchk("R8 below window no change", 3, 0, mk(0, 1, 1, 0, 1));
    n0 = wb_n;
    run(4'd2, B + WSZ + 32'h30, 1, 1'b0);
    chk("R8 above window no write-back", 32'(wb_n), 32'(n0));
    pchk("R8 above window no change", 3, 0, mk(0, 1, 1, 0, 1));
  endtask

  task automatic t_err();
    clear_all();
    install(0, 0, mk(1, 1, 1, 0, 0));
    run(4'd0, la(1, 0), 0, 1'b0);
    chk("R9 zero lines", {31'h0, last_err}, 32'h1);
    run(4'd0, la(1, 0), 262145, 1'b0);
    chk("R9 too many lines", {31'h0, last_err}, 32'h1);
    run(4'd1, la(1, 0), 0, 1'b1);
    chk("R9 zero bytes", {31'h0, last_err}, 32'h1);
    run(4'd1, la(1, 0), 32'h0040_0001, 1'b1);
    chk("R9 too many bytes", {31'h0, last_err}, 32'h1);
    run(4'd15, la(1, 0), 1, 1'b0);
    chk("R9 unknown command", {31'h0, last_err}, 32'h1);
    pchk("R9 array untouched", 0, 0, mk(1, 1, 1, 0, 0));
  endtask

  task automatic t_sweep();
    clear_all();
    wb_n = 0;
    install(0, 2, mk(1, 1, 1, 0, 0));
    install(5, 1, mk(2, 1, 1, 1, 3));
    install(7, 3, mk(4, 0, 1, 0, 0));
    run(4'd7, 0, 0, 1'b0);
    chk("R10 sweep write-back count", 32'(wb_n), 32'd2);
    chk("R10 sweep order first", wb_log[0], la(1, 0));
    chk("R10 sweep order second", wb_log[1], la(2, 5));
    pchk("R10 sweep dirty cleared", 5, 1, mk(2, 1, 0, 1, 3));
    pchk("R10 invalid entry skipped", 7, 3, mk(4, 0, 1, 0, 0));
    run(4'd5, 0, 0, 1'b0);
    pchk("R10 invalidate-all", 0, 2, mk(1, 0, 0, 0, 0));
    pchk("R5 invalidate-all keeps locked", 5, 1, mk(2, 1, 0, 1, 3));
    install(4, 0, mk(8, 1, 1, 0, 0));
    run(4'd6, 0, 0, 1'b0);
    pchk("R10 clean-all", 4, 0, mk(8, 1, 0, 0, 0));
    pchk("R10 clean-all skips invalid", 7, 3, mk(4, 0, 1, 0, 0));
  endtask

  task automatic t_power();
    run(4'd9, 0, 0, 1'b0);
    chk("R11 suspend hold", {31'h0, cpu_hold}, 32'h1);
    pchk("R11 suspend keeps tags", 5, 1, mk(2, 1, 0, 1, 3));
    run(4'd10, 0, 0, 1'b0);
    chk("R11 resume", {31'h0, cpu_hold}, 32'h0);
    run(4'd8, 0, 0, 1'b0);
    chk("R11 disable hold", {31'h0, cpu_hold}, 32'h1);
    pchk("R11 disable invalidates locked", 5, 1, mk(2, 0, 0, 1, 3));
    run(4'd10, 0, 0, 1'b0);
    chk("R11 resume after disable", {31'h0, cpu_hold}, 32'h0);
  endtask

  task automatic t_busy();
    clear_all();
    wb_n = 0;
    install(2, 0, mk(3, 1, 1, 0, 0));
    @(negedge clk);
    req = 1'b1; cmd = 4'd2; req_addr = la(3, 2); req_len = 1; len_in_bytes = 1'b0;
    @(negedge clk);
    req = 1'b0;
    chk("R12 busy during walk", {31'h0, busy}, 32'h1);
    ins_en = 1'b1; ins_set = 3'd6; ins_way = 2'd3; ins_data = mk(1, 1, 0, 0, 0);
    @(negedge clk);
    ins_en = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (ack) break;
      @(negedge clk);
    end
    chk("R12 ack seen", {31'h0, ack}, 32'h1);
    @(negedge clk);
    chk("R12 ack one cycle", {31'h0, ack}, 32'h0);
    pchk("R12 install ignored while busy", 6, 3, 32'h0);
    chk("R7 write-back during busy", wb_log[0], la(3, 2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inv();
    t_bytes();
    t_lock();
    t_clean();
    t_wb();
    t_window();
    t_err();
    t_sweep();
    t_power();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule